// File: doc/BRIEF.md
# 4x4 Integer Core Transform

This block takes a 4x4 tile of signed 9-bit prediction residuals and produces the 16 coefficients of a separable integer transform that approximates a 4-point DCT. The transform matrix holds only the weights ±1 and ±2, so the datapath uses adds, subtracts and one-bit left shifts. The per-position scale factors that a true DCT would need are not applied here. They are left for a quantiser further down the pipeline. Rows are transformed first and columns second.

The same datapath also serves as a second-level transform for DC terms collected from a macroblock. In luma DC mode it applies a 4x4 Hadamard with a rounded halving. In chroma DC mode it applies a 2x2 Hadamard to four values. A tile can arrive in one cycle on a wide bus or as four consecutive rows. Every finished tile is announced by a one-cycle `done` pulse, and the coefficients stay on `coef` until the next result.

Top module: `intxfm4_core`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and every `coef` lane is 0 until the first result.
- R2: With mode 0, the output is Y = C·X·Cᵀ. The rows of C are [1 1 1 1], [2 1 -1 -2], [1 -1 -1 1] and [1 -2 2 -1]. Element (r,c) of X is input index 4r+c, on bits [i*9 +: 9] of `blk_in`. Element (r,c) of Y is lane 4r+c, on bits [i*16 +: 16] of `coef`. All values are two's complement.
- R3: Mode 3 gives exactly the same result as mode 0.
- R4: With mode 1, each lane is floor((v+1)/2), where v is the matching element of H·X·Hᵀ. The rows of H are [1 1 1 1], [1 1 -1 -1], [1 -1 -1 1] and [1 -1 1 -1].
- R5: With mode 2, inputs 0..3 form the 2x2 tile [x0 x1; x2 x3]. Lanes 0..3 carry G·X·Gᵀ in row-major order, with G = [1 1; 1 -1]. Lanes 4..15 are 0, and inputs 4..15 have no effect.
- R6: A cycle with `blk_load` high samples `blk_in` and `mode`. `done` is then high for exactly one cycle, at the second rising edge after the load edge, with the result on `coef`. `coef` holds that result until the next `done`.
- R7: Four cycles with `row_load` high deliver rows 0..3 in order. Element c of a row is on bits [c*9 +: 9] of `row_in`. `mode` is sampled with the fourth row only. `done` rises at the second edge after the fourth row and not earlier.
- R8: Every result is exact in 16 bits over the full input range from -256 to 255, with no wrap-around.
- R9: When `blk_load` and `row_load` are both high, the parallel load wins. The row sequence restarts from row 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0/3 core, 1 luma DC Hadamard, 2 chroma DC Hadamard |
| blk_load | input | 1 | Load the whole tile from `blk_in` |
| blk_in | input | 144 | 16 signed 9-bit samples, index 4r+c |
| row_load | input | 1 | Load one row from `row_in` |
| row_in | input | 36 | 4 signed 9-bit samples of one row |
| done | output | 1 | One-cycle result strobe |
| coef | output | 256 | 16 signed 16-bit coefficients, lane 4r+c |

## Verification
A wrong row counter or a wrongly captured mode shows up as a misplaced row or the wrong transform family on the very next `done`. That happens two edges after the last load. A fault in the butterfly or shift network affects specific lanes in a way that depends on the data. The tests use all-maximum, all-minimum and alternating-sign tiles, mixed with random tiles, so that sign and weight errors reach the ports on the first result. Stray data in the chroma mode appears as nonzero upper lanes. A broken hold appears as `coef` changing between strobes.

// File: rtl/intxfm4_core.sv
module intxfm4_core #(
  parameter int DW = 9,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              blk_load,
  input  logic [16*DW-1:0]  blk_in,
  input  logic              row_load,
  input  logic [4*DW-1:0]   row_in,
  output logic              done,
  output logic [16*CW-1:0]  coef
);
  localparam int N  = 16;
  localparam int IW = DW + 7;
  localparam int LIM = 36 << (DW - 1);

  logic signed [DW-1:0] xb [N];
  logic [1:0]           rcnt;
  logic [1:0]           mq;
  logic                 go;
  logic signed [IW-1:0] tr  [N];
  logic signed [IW-1:0] ty  [N];
  logic signed [IW-1:0] res [N];

  function automatic void pass1(
    input  logic had,
    input  logic signed [IW-1:0] a, b, c, d,
    output logic signed [IW-1:0] y0, y1, y2, y3);
    logic signed [IW-1:0] s0, s1, s2, s3;
    s0 = a + d; s3 = a - d;
    s1 = b + c; s2 = b - c;
    y0 = s0 + s1;
    y2 = s0 - s1;
    if (had) begin
      y1 = s3 + s2;
      y3 = s3 - s2;
    end else begin
      y1 = (s3 <<< 1) + s2;
      y3 = s3 - (s2 <<< 1);
    end
  endfunction

  always_comb begin
    for (int r = 0; r < 4; r++)
      pass1(mq == 2'd1, IW'(xb[4*r]), IW'(xb[4*r+1]), IW'(xb[4*r+2]), IW'(xb[4*r+3]),
            tr[4*r], tr[4*r+1], tr[4*r+2], tr[4*r+3]);
    for (int c = 0; c < 4; c++)
      pass1(mq == 2'd1, tr[c], tr[4+c], tr[8+c], tr[12+c],
            ty[c], ty[4+c], ty[8+c], ty[12+c]);
    for (int i = 0; i < N; i++) res[i] = ty[i];
    if (mq == 2'd1) begin
      for (int i = 0; i < N; i++) res[i] = (ty[i] + IW'(1)) >>> 1;
    end else if (mq == 2'd2) begin
      for (int i = 0; i < N; i++) res[i] = '0;
      res[0] = IW'(xb[0]) + IW'(xb[1]) + IW'(xb[2]) + IW'(xb[3]);
      res[1] = IW'(xb[0]) - IW'(xb[1]) + IW'(xb[2]) - IW'(xb[3]);
      res[2] = IW'(xb[0]) + IW'(xb[1]) - IW'(xb[2]) - IW'(xb[3]);
      res[3] = IW'(xb[0]) - IW'(xb[1]) - IW'(xb[2]) + IW'(xb[3]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= '0;
      mq   <= '0;
      go   <= 1'b0;
      done <= 1'b0;
      coef <= '0;
      for (int i = 0; i < N; i++) xb[i] <= '0;
    end else begin
      go <= 1'b0;
      if (blk_load) begin
        for (int i = 0; i < N; i++) xb[i] <= blk_in[i*DW +: DW];
        mq   <= mode;
        go   <= 1'b1;
        rcnt <= '0;
      end else if (row_load) begin
        for (int c = 0; c < 4; c++) xb[int'(rcnt)*4 + c] <= row_in[c*DW +: DW];
        rcnt <= rcnt + 2'd1;
        if (rcnt == 2'd3) begin
          mq <= mode;
          go <= 1'b1;
        end
      end
      done <= go;
      if (go)
        for (int i = 0; i < N; i++) coef[i*CW +: CW] <= CW'(res[i]);
    end
  end

  logic signed [IW-1:0] in_sum;
  logic                 all_in_range;
  always_comb begin
    in_sum = '0;
    for (int i = 0; i < N; i++) in_sum = in_sum + IW'($signed(blk_in[i*DW +: DW]));
    all_in_range = 1'b1;
    for (int i = 0; i < N; i++)
      if ($signed(coef[i*CW +: CW]) > LIM || $signed(coef[i*CW +: CW]) < -LIM)
        all_in_range = 1'b0;
  end

  assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_load |=> ##1 done);
  assert_dc_is_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_load && mode == 2'd0) |=> ##1 ($signed(coef[CW-1:0]) == $past(in_sum, 2)));
  assert_chroma_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_load && mode == 2'd2) |=> ##1 (coef[16*CW-1:4*CW] == '0));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> all_in_range);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(!go)) |-> $stable(coef));
endmodule

// File: tb/intxfm4_core_tb.sv
module intxfm4_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic blk_load = 1'b0, row_load = 1'b0;
  logic [143:0] blk_in = '0;
  logic [35:0] row_in = '0;
  logic done;
  logic [255:0] coef;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  intxfm4_core dut_i (.clk(clk), .rst_n(rst_n), .mode(mode), .blk_load(blk_load),
    .blk_in(blk_in), .row_load(row_load), .row_in(row_in), .done(done), .coef(coef));

  function automatic int cm(int h, int r, int c);
    int kc [16] = '{1,1,1,1, 2,1,-1,-2, 1,-1,-1,1, 1,-2,2,-1};
    int kh [16] = '{1,1,1,1, 1,1,-1,-1, 1,-1,-1,1, 1,-1,1,-1};
    return h ? kh[4*r+c] : kc[4*r+c];
  endfunction

  task automatic expect_blk(input logic [1:0] m, input int x[16], output int y[16]);
    int t [16];
    int h = (m == 2'd1);
    for (int i = 0; i < 16; i++) y[i] = 0;
    if (m == 2'd2) begin
      y[0] = x[0]+x[1]+x[2]+x[3];
      y[1] = x[0]-x[1]+x[2]-x[3];
      y[2] = x[0]+x[1]-x[2]-x[3];
      y[3] = x[0]-x[1]-x[2]+x[3];
      return;
    end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        t[4*r+c] = 0;
        for (int k = 0; k < 4; k++) t[4*r+c] += cm(h, r, k) * x[4*k+c];
      end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        y[4*r+c] = 0;
        for (int k = 0; k < 4; k++) y[4*r+c] += t[4*r+k] * cm(h, c, k);
        if (h) y[4*r+c] = (y[4*r+c] + 1) >>> 1;
      end
  endtask

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_out(input string req, input logic [1:0] m, input int x[16]);
    int y [16];
    int bad = -1;
    expect_blk(m, x, y);
    for (int i = 15; i >= 0; i--)
      if ($signed(coef[i*16 +: 16]) != y[i]) bad = i;
    if (bad < 0) chk(req, 1'b1, 0, 0);
    else chk(req, 1'b0, $signed(coef[bad*16 +: 16]), y[bad]);
  endtask

  task automatic run_par(input string req, input logic [1:0] m, input int x[16]);
    @(negedge clk);
    for (int i = 0; i < 16; i++) blk_in[i*9 +: 9] = x[i][8:0];
    mode = m; blk_load = 1'b1;
    @(negedge clk);
    blk_load = 1'b0;
    chk("R6 no early done", done == 1'b0, done, 0);
    @(negedge clk);
    chk("R6 done pulse", done == 1'b1, done, 1);
    cmp_out(req, m, x);
  endtask

  task automatic run_rows(input string req, input logic [1:0] m, input int x[16]);
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      if (r > 0) chk("R7 no done mid rows", done == 1'b0, done, 0);
      for (int c = 0; c < 4; c++) row_in[c*9 +: 9] = x[4*r+c][8:0];
      mode = (r == 3) ? m : ~m;
      row_load = 1'b1;
    end
    @(negedge clk);
    row_load = 1'b0;
    chk("R7 no early done", done == 1'b0, done, 0);
    @(negedge clk);
    chk("R7 done pulse", done == 1'b1, done, 1);
    cmp_out(req, m, x);
  endtask

  task automatic rnd_blk(output int x[16]);
    for (int i = 0; i < 16; i++) x[i] = int'($urandom_range(511)) - 256;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int x [16];
    logic [255:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset done", done == 1'b0, done, 0);
    chk("R1 reset coef", coef == '0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", done == 1'b0 && coef == '0, done, 0);

    for (int i = 0; i < 16; i++) x[i] = 255;
    run_par("R8 core all max", 2'd0, x);
    run_par("R4 luma all max", 2'd1, x);
    for (int i = 0; i < 16; i++) x[i] = -256;
    run_par("R8 core all min", 2'd0, x);
    run_par("R4 luma all min", 2'd1, x);
    run_par("R5 chroma all min", 2'd2, x);
    for (int i = 0; i < 16; i++) x[i] = (((i >> 2) + i) & 1) ? -256 : 255;
    run_par("R8 core checker", 2'd0, x);
    for (int i = 0; i < 16; i++) x[i] = ((i & 1) ? -256 : 255) * (((i >> 2) == 1 || (i >> 2) == 2) ? -1 : 1);
    for (int i = 0; i < 16; i++) if (x[i] == 256) x[i] = 255;
    run_par("R8 core mixed extreme", 2'd0, x);
    for (int i = 0; i < 16; i++) x[i] = 0;
    x[5] = -3;
    run_par("R4 luma negative rounding", 2'd1, x);
    x[5] = 1;
    run_par("R4 luma positive rounding", 2'd1, x);

    @(negedge clk);
    held = coef;
    repeat (3) @(negedge clk);
    chk("R6 coef held", coef == held && done == 1'b0, 0, 0);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] m = 2'(n % 4);
      rnd_blk(x);
      case (m)
        2'd0: run_par("R2 random core", m, x);
        2'd1: run_par("R4 random luma", m, x);
        2'd2: run_par("R5 random chroma", m, x);
        default: run_par("R3 random mode3", m, x);
      endcase
    end
    for (int n = 0; n < 12; n++) begin
      rnd_blk(x);
      run_rows("R7 random rows", 2'(n % 4), x);
    end

    rnd_blk(x);
    for (int r = 0; r < 2; r++) begin
      @(negedge clk);
      row_in = 36'($urandom); row_load = 1'b1; mode = 2'd0;
    end
    @(negedge clk);
    for (int i = 0; i < 16; i++) blk_in[i*9 +: 9] = x[i][8:0];
    row_in = 36'($urandom); mode = 2'd0; blk_load = 1'b1; row_load = 1'b1;
    @(negedge clk);
    blk_load = 1'b0; row_load = 1'b0;
    @(negedge clk);
    chk("R9 parallel priority done", done == 1'b1, done, 1);
    cmp_out("R9 parallel wins", 2'd0, x);
    rnd_blk(x);
    run_rows("R9 rows restart", 2'd0, x);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule